// File: doc/BRIEF.md
# Compatibility-Mode Register/Memory Remapper

This block sits between a 16-bit register-file core and its data memory so that the core can run code written for an 8-bit legacy controller. It holds sixteen 16-bit working registers, organised as four banks of four (R0 to R3). It also steers every byte-wide data access either to those registers or to an external data-memory port, which passes the access through unchanged.

A single compatibility bit controls the remapping. When the bit is set, the lowest 32 byte addresses of any data segment are served from the register file, with each register showing up as two consecutive bytes. In the same mode, indirect pointers through R0 and R1 shrink to a zero-extended byte taken from R0 of the active bank. When the bit is clear, every data address goes to memory and indirect pointers are the full 16-bit registers. The core also has a word-wide port to read and write the registers directly.

Top module: `cm_remap_top`

## Requirements
- R1: A synchronous active-low reset clears all sixteen registers to 0x0000.
- R2: With compat_en=1, an access with acc_addr < 32 never raises mem_req or mem_we, whatever the value of acc_seg.
- R3: An aliased access decodes acc_addr[4:3] as the bank, acc_addr[2:1] as the register (0 is R0) and acc_addr[0] as the byte (0 is the low byte). An aliased read returns that byte combinationally on acc_rdata.
- R4: An aliased byte write changes only the addressed half of its register; the other half keeps its value.
- R5: With compat_en=1 and ptr_sel=0, ptr_out is {8'h00, low byte of R0 of bank bank_sel}.
- R6: With compat_en=1 and ptr_sel=1, ptr_out is {8'h00, high byte of R0 of bank bank_sel}.
- R7: With compat_en=0, ptr_out is the full R0 (ptr_sel=0) or the full R1 (ptr_sel=1) of bank bank_sel.
- R8: With compat_en=0, every access, including addresses 0 to 31, is forwarded: mem_req=acc_req, mem_we=acc_we, and segment, address and write data are unchanged. acc_rdata=mem_rdata, and the registers are not touched.
- R9: An address of 32 or more is forwarded unchanged to the memory port in both modes, and acc_rdata returns mem_rdata.
- R10: reg_we writes reg_wdata into register reg_idx of bank reg_bank at the clock edge. If an aliased byte write hits the same register in the same cycle, the byte write sets its half and the word write sets the other half.
- R11: reg_rdata shows the register selected by reg_bank and reg_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| compat_en | input | 1 | Compatibility mode bit |
| bank_sel | input | 2 | Active bank used for pointer generation |
| ptr_sel | input | 1 | Indirect pointer register: 0 = R0, 1 = R1 |
| ptr_out | output | 16 | Effective indirect pointer |
| acc_req | input | 1 | Data access strobe |
| acc_we | input | 1 | Data access is a write |
| acc_seg | input | SEG_W | Data segment of the access |
| acc_addr | input | ADDR_W | Byte address within the segment |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_seg | output | SEG_W | Forwarded segment |
| mem_addr | output | ADDR_W | Forwarded byte address |
| mem_wdata | output | 8 | Forwarded write byte |
| mem_rdata | input | 8 | Read byte from memory |
| reg_we | input | 1 | Word write enable |
| reg_bank | input | 2 | Word port bank |
| reg_idx | input | 2 | Word port register index |
| reg_wdata | input | 16 | Word write data |
| reg_rdata | output | 16 | Word read data |

## Verification
The bench probes the edge of the aliased window at addresses 31 and 32. A design that compares one bit short or long would either leak a memory strobe or shadow a real memory byte. It writes one half of a register and reads back the other half, which exposes a design that writes the full word. It checks that native-mode writes to low addresses leave the registers untouched, and that pointers in compatibility mode have a zero upper byte drawn from R0, never from R1. It also drives a word write and an aliased byte write to the same register in one cycle, which catches a design where one write simply wins over the other.

// File: rtl/cm_remap_pkg.sv
// Shared constants and types for the compatibility remapper.
// Assumes the register width is exactly two bytes.
package cm_remap_pkg;
    localparam int BYTE_W        = 8;
    localparam int REG_W         = 2 * BYTE_W;
    localparam int BANK_W        = 2;
    localparam int IDX_W         = 2;
    localparam int NUM_BANKS     = 1 << BANK_W;
    localparam int REGS_PER_BANK = 1 << IDX_W;
    localparam int NUM_REGS      = NUM_BANKS * REGS_PER_BANK;
    localparam int SEL_W         = BANK_W + IDX_W;
    localparam int ALIAS_SPAN    = NUM_REGS * 2;

    typedef struct packed {
        logic              hit;
        logic [BANK_W-1:0] bank;
        logic [IDX_W-1:0]  idx;
        logic              hi;
    } alias_dec_t;
endpackage

// File: rtl/cm_addr_decode.sv
// Classifies a byte address as aliased (register file) or memory.
// Assumes ADDR_W is large enough to hold the aliased span.
module cm_addr_decode
    import cm_remap_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              compat_en,
    input  logic [ADDR_W-1:0] addr,
    output alias_dec_t        dec
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(ALIAS_SPAN);

    // Split the low address bits into bank, register and byte fields.
    always_comb begin
        dec.hit  = compat_en && (addr < SPAN);
        dec.bank = addr[1+IDX_W +: BANK_W];
        dec.idx  = addr[1 +: IDX_W];
        dec.hi   = addr[0];
    end
endmodule

// File: rtl/cm_regfile.sv
// Sixteen 16-bit registers with a byte write port, a word write port,
// a byte read port, a word read port and an R0/R1 read for one bank.
// Assumes a byte write and a word write may land on one register together.
module cm_regfile
    import cm_remap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [SEL_W-1:0]  byte_sel,
    input  logic              byte_hi,
    input  logic [BYTE_W-1:0] byte_wdata,
    output logic [BYTE_W-1:0] byte_rdata,
    input  logic              word_we,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [REG_W-1:0]  word_wdata,
    output logic [REG_W-1:0]  word_rdata,
    input  logic [BANK_W-1:0] ptr_bank,
    output logic [REG_W-1:0]  r0_word,
    output logic [REG_W-1:0]  r1_word
);
    logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] q;
        logic [REG_W-1:0] nxt;
        logic             word_hit;
        logic             byte_hit;

        assign word_hit = word_we && (word_sel == SEL_W'(g));
        assign byte_hit = byte_we && (byte_sel == SEL_W'(g));

        // Merge the word write with a same-cycle byte write to one half.
        always_comb begin
            nxt = q;
            if (word_hit) begin
                nxt = word_wdata;
            end
            if (byte_hit) begin
                if (byte_hi) begin
                    nxt[REG_W-1:BYTE_W] = byte_wdata;
                end else begin
                    nxt[BYTE_W-1:0] = byte_wdata;
                end
            end
        end

        // Hold the register, clearing it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= nxt;
            end
        end

        assign regs_q[g] = q;
    end

    // Byte read of the aliased register half.
    always_comb begin
        byte_rdata = byte_hi ? regs_q[byte_sel][REG_W-1:BYTE_W]
                             : regs_q[byte_sel][BYTE_W-1:0];
    end

    assign word_rdata = regs_q[word_sel];
    assign r0_word    = regs_q[{ptr_bank, IDX_W'(0)}];
    assign r1_word    = regs_q[{ptr_bank, IDX_W'(1)}];
endmodule

// File: rtl/cm_ptr_gen.sv
// Forms the effective indirect pointer from R0/R1 of the active bank.
// Assumes the register reads are already those of the active bank.
module cm_ptr_gen
    import cm_remap_pkg::*;
(
    input  logic             compat_en,
    input  logic             ptr_sel,
    input  logic [REG_W-1:0] r0_word,
    input  logic [REG_W-1:0] r1_word,
    output logic [REG_W-1:0] ptr_out
);
    // Pick a zero-extended R0 byte in compat mode, else the full register.
    always_comb begin
        if (compat_en) begin
            ptr_out = ptr_sel ? {{BYTE_W{1'b0}}, r0_word[REG_W-1:BYTE_W]}
                              : {{BYTE_W{1'b0}}, r0_word[BYTE_W-1:0]};
        end else begin
            ptr_out = ptr_sel ? r1_word : r0_word;
        end
    end
endmodule

// File: rtl/cm_remap_top.sv
// Top of the compatibility remapper: steers byte accesses to the register
// file or the memory port and forms indirect pointers.
// Assumes the memory port answers reads combinationally.
module cm_remap_top
    import cm_remap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              compat_en,
    input  logic [1:0]        bank_sel,
    input  logic              ptr_sel,
    output logic [15:0]       ptr_out,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [SEG_W-1:0]  acc_seg,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [7:0]        acc_wdata,
    output logic [7:0]        acc_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [SEG_W-1:0]  mem_seg,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              reg_we,
    input  logic [1:0]        reg_bank,
    input  logic [1:0]        reg_idx,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);
    alias_dec_t       dec;
    logic [7:0]       alias_rdata;
    logic [15:0]      r0_word;
    logic [15:0]      r1_word;

    cm_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .compat_en (compat_en),
        .addr      (acc_addr),
        .dec       (dec)
    );

    cm_regfile u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (acc_req && acc_we && dec.hit),
        .byte_sel   ({dec.bank, dec.idx}),
        .byte_hi    (dec.hi),
        .byte_wdata (acc_wdata),
        .byte_rdata (alias_rdata),
        .word_we    (reg_we),
        .word_sel   ({reg_bank, reg_idx}),
        .word_wdata (reg_wdata),
        .word_rdata (reg_rdata),
        .ptr_bank   (bank_sel),
        .r0_word    (r0_word),
        .r1_word    (r1_word)
    );

    cm_ptr_gen u_ptr (
        .compat_en (compat_en),
        .ptr_sel   (ptr_sel),
        .r0_word   (r0_word),
        .r1_word   (r1_word),
        .ptr_out   (ptr_out)
    );

    // Forward non-aliased accesses and suppress strobes for aliased ones.
    always_comb begin
        mem_req   = acc_req && !dec.hit;
        mem_we    = acc_req && acc_we && !dec.hit;
        mem_seg   = acc_seg;
        mem_addr  = acc_addr;
        mem_wdata = acc_wdata;
        acc_rdata = dec.hit ? alias_rdata : mem_rdata;
    end
endmodule

// File: rtl/cm_remap_chk.sv
// Property checker for cm_remap_top, attached by bind.
module cm_remap_chk #(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              compat_en,
    input logic [15:0]       ptr_out,
    input logic              acc_req,
    input logic              acc_we,
    input logic [SEG_W-1:0]  acc_seg,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [SEG_W-1:0]  mem_seg,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              reg_we,
    input logic [1:0]        reg_bank,
    input logic [1:0]        reg_idx,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata
);
    logic low_addr;
    logic alias_wr;
    assign low_addr = acc_addr < ADDR_W'(32);
    assign alias_wr = acc_req && acc_we && compat_en && low_addr;

    // R2: aliased accesses never reach memory
    p_alias_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && compat_en && low_addr) |-> (!mem_req && !mem_we));

    // R8: native mode forwards every access
    p_native_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !compat_en) |-> (mem_req && mem_we == acc_we
                                      && mem_addr == acc_addr && mem_seg == acc_seg));

    // R9: high addresses forward in both modes
    p_high_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !low_addr) |-> (mem_req && mem_addr == acc_addr));

    // R8: no memory strobe without a request
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |-> (!mem_req && !mem_we));

    // R5 / R6: compat pointers are zero-extended bytes
    p_ptr_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        compat_en |-> (ptr_out[15:8] == 8'h00));

    // R10: an uncontested word write reads back
    p_word_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !alias_wr) |=>
        (!($stable(reg_bank) && $stable(reg_idx)) || reg_rdata == $past(reg_wdata)));
endmodule

bind cm_remap_top cm_remap_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .compat_en (compat_en),
    .ptr_out   (ptr_out),
    .acc_req   (acc_req),
    .acc_we    (acc_we),
    .acc_seg   (acc_seg),
    .acc_addr  (acc_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_seg   (mem_seg),
    .mem_addr  (mem_addr),
    .reg_we    (reg_we),
    .reg_bank  (reg_bank),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/cm_remap_top_tb.sv
// Self-checking bench: a vector table for the access path, then directed
// tests for pointers, the word port, collisions and reset.
module cm_remap_top_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        compat_en;
    logic [1:0]  bank_sel;
    logic        ptr_sel;
    logic [15:0] ptr_out;
    logic        acc_req;
    logic        acc_we;
    logic [7:0]  acc_seg;
    logic [15:0] acc_addr;
    logic [7:0]  acc_wdata;
    logic [7:0]  acc_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [7:0]  mem_seg;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        reg_we;
    logic [1:0]  reg_bank;
    logic [1:0]  reg_idx;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    // Memory model: a read returns the low address byte XOR 0xA5.
    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

    cm_remap_top u_dut (.*);

    typedef struct packed {
        logic        compat;
        logic        we;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        exp_mem;
        logic        chk_rd;
        logic [7:0]  exp_rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 16'h0000, 8'h11, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b1, 16'h0001, 8'h22, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b1, 16'h001F, 8'h33, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b1, 8'h11},
        '{1'b1, 1'b0, 16'h0001, 8'h00, 1'b0, 1'b1, 8'h22},
        '{1'b1, 1'b0, 16'h001F, 8'h00, 1'b0, 1'b1, 8'h33},
        '{1'b1, 1'b0, 16'h001E, 8'h00, 1'b0, 1'b1, 8'h00},
        '{1'b1, 1'b0, 16'h0020, 8'h00, 1'b1, 1'b1, 8'h85},
        '{1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 1'b1, 8'hA5},
        '{1'b0, 1'b1, 16'h0005, 8'h44, 1'b1, 1'b0, 8'h00},
        '{1'b1, 1'b0, 16'h0005, 8'h00, 1'b0, 1'b1, 8'h00},
        '{1'b1, 1'b1, 16'h000A, 8'h55, 1'b0, 1'b0, 8'h00},
        '{1'b1, 1'b0, 16'h000A, 8'h00, 1'b0, 1'b1, 8'h55},
        '{1'b0, 1'b0, 16'h1234, 8'h00, 1'b1, 1'b1, 8'h91},
        '{1'b1, 1'b1, 16'h0040, 8'h66, 1'b1, 1'b0, 8'h00},
        '{1'b1, 1'b0, 16'h0008, 8'h00, 1'b0, 1'b1, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_req   = 1'b0;
        acc_we    = 1'b0;
        acc_seg   = 8'h00;
        acc_addr  = 16'h0000;
        acc_wdata = 8'h00;
        reg_we    = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        rst_n = 1'b0; compat_en = 1'b1; bank_sel = 2'd0; ptr_sel = 1'b0;
        reg_bank = 2'd0; reg_idx = 2'd0; reg_wdata = 16'h0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: registers cleared after reset
        reg_bank = 2'd3; reg_idx = 2'd3;
        #5 chk("R1 reset bank3 R3", reg_rdata, 16'h0000);
        reg_bank = 2'd0; reg_idx = 2'd0;
        #1 chk("R1 reset bank0 R0", reg_rdata, 16'h0000);

        // Vector table: R2 R3 R4 alias rows, R8 R9 pass-through rows
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            compat_en = VECS[i].compat;
            acc_req   = 1'b1;
            acc_we    = VECS[i].we;
            acc_seg   = 8'h3C;
            acc_addr  = VECS[i].addr;
            acc_wdata = VECS[i].wdata;
            #5;
            if (VECS[i].exp_mem) begin
                chk("R8 R9 mem_req", {15'd0, mem_req}, 16'd1);
                chk("R8 R9 mem_we", {15'd0, mem_we}, {15'd0, VECS[i].we});
                chk("R8 R9 mem_addr", mem_addr, VECS[i].addr);
                chk("R8 R9 mem_seg", {8'd0, mem_seg}, 16'h003C);
            end else begin
                chk("R2 mem_req suppressed", {15'd0, mem_req}, 16'd0);
                chk("R2 mem_we suppressed", {15'd0, mem_we}, 16'd0);
            end
            if (VECS[i].chk_rd) begin
                chk(VECS[i].exp_mem ? "R9 R8 read" : "R3 R4 alias read",
                    {8'd0, acc_rdata}, {8'd0, VECS[i].exp_rd});
            end
        end
        @(negedge clk);
        idle_inputs();

        // R11: word read shows bytes written through the alias
        reg_bank = 2'd0; reg_idx = 2'd0;
        #5 chk("R11 word read bank0 R0", reg_rdata, 16'h2211);
        reg_bank = 2'd3; reg_idx = 2'd3;
        #1 chk("R4 R11 bank3 R3 half", reg_rdata, 16'h3300);

        // R2: segment does not matter for aliasing
        @(negedge clk);
        compat_en = 1'b1; acc_req = 1'b1; acc_seg = 8'h7F; acc_addr = 16'h0003;
        #5 chk("R2 other segment", {15'd0, mem_req}, 16'd0);
        @(negedge clk);
        idle_inputs();

        // Load bank2 R0/R1 through the word port
        reg_we = 1'b1; reg_bank = 2'd2; reg_idx = 2'd0; reg_wdata = 16'hBEEF;
        @(negedge clk);
        reg_idx = 2'd1; reg_wdata = 16'h1357;
        @(negedge clk);
        reg_we = 1'b0;
        #5 chk("R10 word write bank2 R1", reg_rdata, 16'h1357);

        // Pointer generation
        bank_sel = 2'd2; compat_en = 1'b1; ptr_sel = 1'b0;
        #1 chk("R5 compat R0 low", ptr_out, 16'h00EF);
        ptr_sel = 1'b1;
        #1 chk("R6 compat R0 high", ptr_out, 16'h00BE);
        compat_en = 1'b0; ptr_sel = 1'b0;
        #1 chk("R7 native R0", ptr_out, 16'hBEEF);
        ptr_sel = 1'b1;
        #1 chk("R7 native R1", ptr_out, 16'h1357);
        bank_sel = 2'd0; compat_en = 1'b1; ptr_sel = 1'b0;
        #1 chk("R5 bank0 R0 low", ptr_out, 16'h0011);
        ptr_sel = 1'b1;
        #1 chk("R6 bank0 R0 high", ptr_out, 16'h0022);

        // R3: address 16 is bank2 R0 low
        acc_req = 1'b1; acc_addr = 16'h0010;
        #1 chk("R3 addr16 bank2 R0 low", {8'd0, acc_rdata}, 16'h00EF);
        acc_addr = 16'h0013;
        #1 chk("R3 addr19 bank2 R1 high", {8'd0, acc_rdata}, 16'h0013);

        // R10: word write and alias byte write to bank1 R2 in one cycle
        @(negedge clk);
        idle_inputs();
        compat_en = 1'b1;
        reg_we = 1'b1; reg_bank = 2'd1; reg_idx = 2'd2; reg_wdata = 16'hAAAA;
        acc_req = 1'b1; acc_we = 1'b1; acc_addr = 16'h000D; acc_wdata = 8'h5C;
        @(negedge clk);
        idle_inputs();
        #5 chk("R10 merged collision", reg_rdata, 16'h5CAA);
        acc_req = 1'b1; acc_addr = 16'h000C;
        #1 chk("R3 R10 addr12 low", {8'd0, acc_rdata}, 16'h00AA);

        // R1: reset in mid-run clears the registers
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #5 chk("R1 re-reset bank1 R2", reg_rdata, 16'h0000);
        bank_sel = 2'd2; compat_en = 1'b0; ptr_sel = 1'b0;
        #1 chk("R1 re-reset pointer", ptr_out, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end
endmodule